// File: doc/BRIEF.md
# Subword Mix and Permute Unit

This unit rearranges the contents of 64-bit words without touching memory. It treats each 64-bit operand as four 16-bit halfwords or two 32-bit words. It can interleave pieces of two source operands, or rebuild one operand's halfwords in any order, with repeats allowed. An execution pipeline uses it as a single-cycle register-to-register stage.

Halfwords are numbered 1 to 4 from the most significant end: halfword 1 is bits 63:48 and halfword 4 is bits 15:0. Source halfwords are written a1..a4 for `src_a` and b1..b4 for `src_b`. The result is written from the most significant halfword down.

The mode code `op_sel` selects the operation:

| `op_sel` | Operation |
|---|---|
| 2'b00 | halfword interleave |
| 2'b01 | word interleave |
| 2'b10 | permute |
| 2'b11 | reserved |

`take_right` picks between the left and right form of an interleave. `perm_ctl` steers the permute. The result register captures the new value on every rising clock edge.

Top module: `subword_shuffle`

## Requirements
- R1: While `rst_n` is low, `result` is 64'h0.
- R2: With `op_sel`=2'b00 and `take_right`=0, the next `result` is a1,b1,a3,b3.
- R3: With `op_sel`=2'b00 and `take_right`=1, the next `result` is a2,b2,a4,b4.
- R4: With `op_sel`=2'b01 and `take_right`=0, the next `result` is a1,a2,b1,b2. This is the upper word of `src_a` above the upper word of `src_b`.
- R5: With `op_sel`=2'b01 and `take_right`=1, the next `result` is a3,a4,b3,b4. This is the lower word of `src_a` above the lower word of `src_b`.
- R6: With `op_sel`=2'b10, `perm_ctl` is read as four 2-bit fields.
  - Field `perm_ctl[7-2k:6-2k]` fills destination halfword k+1, for k = 0 to 3.
  - A field value v places source halfword a(v+1) there, so 0 selects a1 and 3 selects a4.
  - The same source halfword may fill several destinations.
- R7: In permute mode, `src_b` and `take_right` have no effect on `result`.
- R8: In both interleave modes, `perm_ctl` has no effect on `result`.
- R9: With `op_sel`=2'b11, the next `result` is 64'h0.
- R10: `result` depends only on the inputs sampled at the most recent rising clock edge. It shows them exactly one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand, used only by the interleave modes |
| op_sel | input | 2 | Mode: 00 halfword interleave, 01 word interleave, 10 permute, 11 reserved |
| take_right | input | 1 | 0 selects the left interleave form, 1 selects the right form |
| perm_ctl | input | 8 | Four 2-bit source selectors, most significant destination first |
| result | output | 64 | Registered rearranged word |

## Verification
The assertions assume that every input is a known value at each rising edge once reset is released. They compare `result` with the inputs captured one edge earlier, so they need no other history. The bench changes inputs only just after a clock edge and always drives defined values. It runs every one of the 256 permute codes and all four interleave forms, and it varies the unused operands on purpose to show that they have no effect.

// File: rtl/subword_shuffle.sv
module subword_shuffle #(
  parameter int HW    = 16,
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [HW*LANES-1:0]   src_a,
  input  logic [HW*LANES-1:0]   src_b,
  input  logic [1:0]            op_sel,
  input  logic                  take_right,
  input  logic [2*LANES-1:0]    perm_ctl,
  output logic [HW*LANES-1:0]   result
);
  localparam int DW   = HW * LANES;
  localparam int HALF = DW / 2;

  logic [HW-1:0] a_hw [LANES];
  logic [HW-1:0] b_hw [LANES];
  logic [DW-1:0] mix_half, mix_word, perm_out, next_val;

  for (genvar i = 0; i < LANES; i++) begin : g_split
    assign a_hw[i] = src_a[DW-1-HW*i -: HW];
    assign b_hw[i] = src_b[DW-1-HW*i -: HW];
    assign perm_out[DW-1-HW*i -: HW] = a_hw[perm_ctl[2*LANES-1-2*i -: 2]];
  end

  for (genvar p = 0; p < LANES/2; p++) begin : g_mix
    localparam int SRC = 2*p;
    assign mix_half[DW-1-2*HW*p -: HW]    = take_right ? a_hw[SRC+1] : a_hw[SRC];
    assign mix_half[DW-1-2*HW*p-HW -: HW] = take_right ? b_hw[SRC+1] : b_hw[SRC];
  end

  assign mix_word = take_right ? {src_a[HALF-1:0], src_b[HALF-1:0]}
                               : {src_a[DW-1:HALF], src_b[DW-1:HALF]};

  always_comb begin
    unique case (op_sel)
      2'b00:   next_val = mix_half;
      2'b01:   next_val = mix_word;
      2'b10:   next_val = perm_out;
      default: next_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result <= '0;
    else        result <= next_val;
  end
endmodule

// File: rtl/subword_shuffle_checks.sv
module subword_shuffle_checks (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] src_a,
  input logic [63:0] src_b,
  input logic [1:0]  op_sel,
  input logic        take_right,
  input logic [7:0]  perm_ctl,
  input logic [63:0] result
);
  assert_reset_zero_R1: assert property (@(posedge clk) !rst_n |=> result == 64'h0);

  assert_mix_half_left_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b00 && !take_right) |=>
      result == {$past(src_a[63:48]), $past(src_b[63:48]), $past(src_a[31:16]), $past(src_b[31:16])});

  assert_mix_half_right_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b00 && take_right) |=>
      result == {$past(src_a[47:32]), $past(src_b[47:32]), $past(src_a[15:0]), $past(src_b[15:0])});

  assert_mix_word_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b01 && !take_right) |=>
      result == {$past(src_a[63:32]), $past(src_b[63:32])});

  assert_mix_word_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b01 && take_right) |=>
      result == {$past(src_a[31:0]), $past(src_b[31:0])});

  for (genvar k = 0; k < 4; k++) begin : g_perm
    assert_perm_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 2'b10) |=>
        result[63-16*k -: 16] ==
          16'($past(src_a) >> {~$past(perm_ctl[7-2*k -: 2]), 4'b0000}));
  end

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b11) |=> result == 64'h0);
endmodule

bind subword_shuffle subword_shuffle_checks chk_i (
  .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .op_sel(op_sel),
  .take_right(take_right), .perm_ctl(perm_ctl), .result(result)
);

// File: tb/subword_shuffle_tb_top.sv
`timescale 1ns/1ps
module subword_shuffle_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_a = '0, src_b = '0, result;
  logic [1:0]  op_sel = '0;
  logic        take_right = 1'b0;
  logic [7:0]  perm_ctl = '0;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  subword_shuffle dut_i (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .op_sel(op_sel),
    .take_right(take_right), .perm_ctl(perm_ctl), .result(result)
  );

  function automatic logic [15:0] hw(logic [63:0] w, int n);
    return w[79-16*n -: 16];
  endfunction

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, logic [1:0] op,
                                        logic r, logic [7:0] ctl);
    logic [15:0] q[$];
    logic [63:0] out = '0;
    case (op)
      2'd0: q = r ? '{hw(a,2), hw(b,2), hw(a,4), hw(b,4)} : '{hw(a,1), hw(b,1), hw(a,3), hw(b,3)};
      2'd1: q = r ? '{hw(a,3), hw(a,4), hw(b,3), hw(b,4)} : '{hw(a,1), hw(a,2), hw(b,1), hw(b,2)};
      2'd2: for (int k = 0; k < 4; k++) q.push_back(hw(a, int'(ctl[7-2*k -: 2]) + 1));
      default: q = '{16'h0, 16'h0, 16'h0, 16'h0};
    endcase
    foreach (q[i]) out = {out[47:0], q[i]};
    return out;
  endfunction

  task automatic check(string tag, logic [63:0] exp);
    checks++;
    if (result !== exp) begin
      failures++;
      $display("FAIL %s: result=%h expected=%h", tag, result, exp);
    end
  endtask

  task automatic step(string tag, logic [63:0] a, logic [63:0] b, logic [1:0] op,
                      logic r, logic [7:0] ctl);
    logic [63:0] exp;
    src_a = a; src_b = b; op_sel = op; take_right = r; perm_ctl = ctl;
    exp = model(a, b, op, r, ctl);
    @(posedge clk); #1;
    check(tag, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog: result=%h expected=completion", result);
    finish_run();
  end

  initial begin
    logic [63:0] a, b;
    logic [63:0] held;
    src_a = 64'hFFFF_FFFF_FFFF_FFFF; op_sel = 2'b01;
    repeat (3) @(posedge clk);
    #1 check("R1", 64'h0);
    rst_n = 1'b1;

    step("R2", 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 2'b00, 1'b0, 8'h00);
    step("R3", 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 2'b00, 1'b1, 8'h00);
    step("R4", 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 2'b01, 1'b0, 8'h00);
    step("R5", 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 2'b01, 1'b1, 8'h00);
    step("R9", 64'hDEAD_BEEF_CAFE_F00D, 64'h0123_4567_89AB_CDEF, 2'b11, 1'b0, 8'hE4);

    for (int c = 0; c < 256; c++) begin
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      step("R6", a, b, 2'b10, c[0], c[7:0]);
    end
    step("R6", 64'hA1A1_B2B2_C3C3_D4D4, 64'h0, 2'b10, 1'b0, 8'hE4);
    step("R6", 64'hA1A1_B2B2_C3C3_D4D4, 64'h0, 2'b10, 1'b0, 8'h1B);
    step("R6", 64'hA1A1_B2B2_C3C3_D4D4, 64'h0, 2'b10, 1'b0, 8'hAA);

    for (int i = 0; i < 4; i++) begin
      a = {$urandom, $urandom};
      step("R7", a, 64'h0, 2'b10, 1'b0, 8'h9C);
      held = result;
      step("R7", a, ~64'h0, 2'b10, 1'b1, 8'h9C);
      checks++;
      if (result !== held) begin
        failures++;
        $display("FAIL R7: result=%h expected=%h", result, held);
      end
    end

    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 256; c += 37) begin
        a = {$urandom, $urandom}; b = {$urandom, $urandom};
        step("R8", a, b, m[1] ? 2'b01 : 2'b00, m[0], c[7:0]);
      end
    end

    for (int i = 0; i < 40; i++) begin
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      step("R10", a, b, 2'($urandom), 1'($urandom), 8'($urandom));
    end

    src_a = 64'h1234_5678_9ABC_DEF0; op_sel = 2'b00;
    #1 rst_n = 1'b0;
    #1 check("R1", 64'h0);
    @(posedge clk); #1 check("R1", 64'h0);
    rst_n = 1'b1;
    step("R10", 64'h1234_5678_9ABC_DEF0, 64'h0, 2'b01, 1'b1, 8'h00);
    finish_run();
  end
endmodule